// File: doc/BRIEF.md
# In-Order Multi-Op Retirement Buffer

This block tracks in-flight instructions in program order so that work done out of order can be committed in order. Each instruction takes one slot in a circular buffer of `DEPTH` entries. An instruction is made of one to `MAX_UOPS` micro-ops. Execution units report each finished micro-op against the slot index that the buffer handed out at allocation. A slot counts as done once it has received as many reports as it has micro-ops. From the head of the buffer, up to `RET_WIDTH` done slots leave per cycle, in strict order.

Branch slots also record the predicted direction at allocation and the resolved direction from their completion reports. When a branch retires with a resolved direction that differs from its prediction, the buffer does three things. It retires that branch, raises a one-cycle flush toward the fetch side and the predictor carrying the correct direction, and discards every younger slot. A recovery window of `RECOV_CYCLES` cycles then holds off new allocation.

Allocation is a valid/ready stream. An instruction is taken on a clock edge where `alloc_valid` and `alloc_ready` are both high, and its fields are sampled only on that edge. `alloc_ready` depends only on internal state, never on `alloc_valid`. Completion reports, retire lanes and the flush output have no back-pressure: a report is always consumed, and retire and flush outputs are valid for exactly one cycle.

Top module: `rob_retire_unit`

## Requirements
- R1: The first instruction accepted after reset gets index 0 on `alloc_idx`. Each later accepted instruction gets the previous index plus one, modulo 16.
- R2: While 16 instructions are held, `alloc_ready` is low and no instruction is accepted.
- R3: An instruction carries a micro-op count of 1 to 4 in `alloc_nuops` (binary). It does not retire until that many completion reports have named its index. Reports naming an index that holds no instruction change nothing.
- R4: An instruction never retires before any older instruction. A done instruction behind an unfinished one waits.
- R5: At most 3 instructions retire per cycle. The retire lanes fill from lane 0 without gaps: lane k carries the k-th oldest instruction in bits [4k+3:4k] of `ret_idx`.
- R6: An instruction whose final completion report is presented in cycle t, with all older instructions retired or retiring, shows on a retire lane in cycle t+1.
- R7: Reports presented on both completion ports in the same cycle are all counted, including two reports naming the same index.
- R8: A branch whose resolved direction (the direction on its last report, 1 = taken) differs from its prediction retires and raises `flush_valid` for that cycle. In that cycle `flush_idx` is its index and `flush_taken` is the resolved direction. No younger instruction retires afterwards. A correctly predicted branch retires without a flush.
- R9: `alloc_ready` is low in the flush cycle and the 10 cycles after it. The next accepted instruction gets the flushed branch's index plus one.
- R10: Out of reset, `alloc_ready` is high and `ret_valid` and `flush_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Buffer can take an instruction this cycle |
| alloc_nuops | input | 3 | Micro-op count, 1 to 4 |
| alloc_branch | input | 1 | Instruction is a branch |
| alloc_pred_taken | input | 1 | Predicted direction of the branch |
| alloc_idx | output | 4 | Index given to the instruction taken this cycle |
| cpl_valid | input | 2 | One completion report per port |
| cpl_idx | input | 8 | Slot index per port, port p in bits [4p+3:4p] |
| cpl_taken | input | 2 | Resolved branch direction per port |
| ret_valid | output | 3 | Retire lane valid |
| ret_idx | output | 12 | Retiring index per lane |
| flush_valid | output | 1 | Mispredict: notify predictor and discard younger |
| flush_idx | output | 4 | Index of the mispredicted branch |
| flush_taken | output | 1 | Correct direction for the redirect |

## Verification
Completion reports arrive in several orders. They come youngest first, split across cycles for multi-micro-op slots, two at once on the same slot, and for more done slots than one cycle can retire. These orders separate true in-order retirement from retirement that merely follows completion. Mispredicted branches are placed both on lane 0 and behind an older slot on lane 1, with a done younger slot behind them. This shows that the flush cuts the lanes at the branch and discards the younger work. A run that fills all 16 slots checks back-pressure. Stale reports sent to an empty slot, which is then reallocated, show that such reports are ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Allocation request fields as captured into a slot.
  typedef struct packed {
    logic [2:0] nuops;
    logic       branch;
    logic       pred_taken;
  } rob_alloc_t;

  // Per-slot bookkeeping held in the entry array.
  typedef struct packed {
    logic       vld;
    logic [2:0] total;
    logic [2:0] done_cnt;
    logic       branch;
    logic       pred;
    logic       actual;
  } rob_slot_t;
endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_CPL = 2,
  parameter int IDXW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDXW-1:0]         wr_idx,
  input  rob_alloc_t              wr_req,
  input  logic [NUM_CPL-1:0]      cpl_valid,
  input  logic [NUM_CPL*IDXW-1:0] cpl_idx,
  input  logic [NUM_CPL-1:0]      cpl_taken,
  input  logic [DEPTH-1:0]        clr_mask,
  input  logic                    flush,
  output logic [DEPTH-1:0]        ent_done,
  output logic [DEPTH-1:0]        ent_mis,
  output logic [DEPTH-1:0]        ent_act
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot_t  s;
    logic [2:0] inc;
    logic       hit_any;
    logic       hit_taken;

    // Sum the reports that name this slot this cycle; the last port wins the direction.
    always_comb begin
      inc       = '0;
      hit_any   = 1'b0;
      hit_taken = s.actual;
      for (int p = 0; p < NUM_CPL; p++) begin
        if (cpl_valid[p] && (cpl_idx[p*IDXW +: IDXW] == IDXW'(i))) begin
          inc       = inc + 3'd1;
          hit_any   = 1'b1;
          hit_taken = cpl_taken[p];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s <= '0;
      end else if (flush) begin
        s.vld <= 1'b0;
      end else if (wr_en && (wr_idx == IDXW'(i))) begin
        s.vld      <= 1'b1;
        s.total    <= wr_req.nuops;
        s.done_cnt <= '0;
        s.branch   <= wr_req.branch;
        s.pred     <= wr_req.pred_taken;
        s.actual   <= 1'b0;
      end else if (clr_mask[i]) begin
        s.vld <= 1'b0;
      end else if (s.vld && hit_any) begin
        s.done_cnt <= s.done_cnt + inc;
        if (s.branch) s.actual <= hit_taken;
      end
    end

    assign ent_done[i] = s.vld && (s.done_cnt == s.total);
    assign ent_mis[i]  = ent_done[i] && s.branch && (s.actual != s.pred);
    assign ent_act[i]  = s.actual;

    // R3: a live slot never counts more completions than it has micro-ops
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      s.vld |-> (s.done_cnt <= s.total));
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH     = 16,
  parameter int RET_WIDTH = 3,
  parameter int IDXW      = 4,
  parameter int CNTW      = 5,
  parameter int NW        = 2
) (
  input  logic [IDXW-1:0]           head,
  input  logic [CNTW-1:0]           count,
  input  logic [DEPTH-1:0]          ent_done,
  input  logic [DEPTH-1:0]          ent_mis,
  output logic [RET_WIDTH-1:0]      ret_valid,
  output logic [RET_WIDTH*IDXW-1:0] ret_idx,
  output logic [NW-1:0]             ret_num,
  output logic [DEPTH-1:0]          clr_mask,
  output logic                      mis_hit,
  output logic [IDXW-1:0]           mis_idx
);

  // Walk from the head; stop at the first slot that is not done or after a mispredict.
  always_comb begin
    logic            go;
    logic [IDXW-1:0] idx;
    go        = 1'b1;
    ret_valid = '0;
    ret_idx   = '0;
    ret_num   = '0;
    clr_mask  = '0;
    mis_hit   = 1'b0;
    mis_idx   = '0;
    for (int k = 0; k < RET_WIDTH; k++) begin
      idx = head + IDXW'(k);
      if (go && (CNTW'(k) < count) && ent_done[idx]) begin
        ret_valid[k]              = 1'b1;
        ret_idx[k*IDXW +: IDXW]   = idx;
        ret_num                   = ret_num + NW'(1);
        clr_mask[idx]             = 1'b1;
        if (ent_mis[idx]) begin
          mis_hit = 1'b1;
          mis_idx = idx;
          go      = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH  = 16,
  parameter int IDXW   = 4,
  parameter int CNTW   = 5,
  parameter int NW     = 2,
  parameter int RECOV  = 10,
  parameter int RCW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [NW-1:0]   ret_num,
  input  logic            mis_hit,
  input  logic [IDXW-1:0] mis_idx,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [CNTW-1:0] count,
  output logic            alloc_ready,
  output logic            alloc_fire
);

  logic [RCW-1:0] recov;

  assign alloc_ready = (count != CNTW'(DEPTH)) && (recov == '0) && !mis_hit;
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      recov <= '0;
    end else if (mis_hit) begin
      head  <= mis_idx + IDXW'(1);
      tail  <= mis_idx + IDXW'(1);
      count <= '0;
      recov <= RCW'(RECOV);
    end else begin
      head  <= head + IDXW'(ret_num);
      tail  <= tail + IDXW'(alloc_fire);
      count <= count + CNTW'(alloc_fire) - CNTW'(ret_num);
      if (recov != '0) recov <= recov - RCW'(1);
    end
  end

  // R2: occupancy never exceeds the buffer size
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  // R2: a full buffer refuses allocation
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNTW'(DEPTH)) |-> !alloc_ready);

  // R1: each accepted instruction advances the tail by one
  a_r1_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (tail == $past(tail) + IDXW'(1)));

  // R9: a flush empties the buffer and starts the recovery window
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    mis_hit |=> ((count == '0) && !alloc_ready && (recov == RCW'(RECOV))));

endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit
  import rob_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int RET_WIDTH    = 3,
  parameter int NUM_CPL      = 2,
  parameter int MAX_UOPS     = 4,
  parameter int RECOV_CYCLES = 10,
  localparam int IDXW = $clog2(DEPTH),
  localparam int UOPW = $clog2(MAX_UOPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [UOPW-1:0]           alloc_nuops,
  input  logic                      alloc_branch,
  input  logic                      alloc_pred_taken,
  output logic [IDXW-1:0]           alloc_idx,
  input  logic [NUM_CPL-1:0]        cpl_valid,
  input  logic [NUM_CPL*IDXW-1:0]   cpl_idx,
  input  logic [NUM_CPL-1:0]        cpl_taken,
  output logic [RET_WIDTH-1:0]      ret_valid,
  output logic [RET_WIDTH*IDXW-1:0] ret_idx,
  output logic                      flush_valid,
  output logic [IDXW-1:0]           flush_idx,
  output logic                      flush_taken
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int NW   = $clog2(RET_WIDTH + 1);
  localparam int RCW  = $clog2(RECOV_CYCLES + 1);

  logic [IDXW-1:0]  head, tail;
  logic [CNTW-1:0]  count;
  logic             alloc_fire;
  logic [NW-1:0]    ret_num;
  logic [DEPTH-1:0] clr_mask, ent_done, ent_mis, ent_act;
  logic             mis_hit;
  logic [IDXW-1:0]  mis_idx;
  rob_alloc_t       req;

  assign req.nuops      = 3'(alloc_nuops);
  assign req.branch     = alloc_branch;
  assign req.pred_taken = alloc_pred_taken;

  rob_ptr_ctrl #(
    .DEPTH(DEPTH), .IDXW(IDXW), .CNTW(CNTW), .NW(NW),
    .RECOV(RECOV_CYCLES), .RCW(RCW)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .ret_num(ret_num), .mis_hit(mis_hit), .mis_idx(mis_idx),
    .head(head), .tail(tail), .count(count),
    .alloc_ready(alloc_ready), .alloc_fire(alloc_fire)
  );

  rob_entry_array #(
    .DEPTH(DEPTH), .NUM_CPL(NUM_CPL), .IDXW(IDXW)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(tail), .wr_req(req),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_taken(cpl_taken),
    .clr_mask(clr_mask), .flush(mis_hit),
    .ent_done(ent_done), .ent_mis(ent_mis), .ent_act(ent_act)
  );

  rob_retire_sel #(
    .DEPTH(DEPTH), .RET_WIDTH(RET_WIDTH), .IDXW(IDXW), .CNTW(CNTW), .NW(NW)
  ) u_sel (
    .head(head), .count(count), .ent_done(ent_done), .ent_mis(ent_mis),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_num(ret_num),
    .clr_mask(clr_mask), .mis_hit(mis_hit), .mis_idx(mis_idx)
  );

  assign alloc_idx   = tail;
  assign flush_valid = mis_hit;
  assign flush_idx   = mis_idx;
  assign flush_taken = ent_act[mis_idx];

  // R3: accepted micro-op counts lie in the legal range
  a_r3_uop_range: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> ((alloc_nuops != '0) && (alloc_nuops <= UOPW'(MAX_UOPS))));

  // R4: nothing retires from an empty buffer
  a_r4_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (|ret_valid) |-> (count != '0));

  // R8: a flush always coincides with the branch retiring on a lane
  a_r8_flush_retires: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> ret_valid[0]);

  // R9: no allocation is accepted in the flush cycle
  a_r9_no_alloc_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_fire);

endmodule

// File: tb/tb_rob_retire_unit.sv
`timescale 1ns/1ps
module tb_rob_retire_unit;
  localparam int IDXW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_nuops = 3'd1;
  logic        alloc_branch = 1'b0;
  logic        alloc_pred_taken = 1'b0;
  logic [3:0]  alloc_idx;
  logic [1:0]  cpl_valid = '0;
  logic [7:0]  cpl_idx = '0;
  logic [1:0]  cpl_taken = '0;
  logic [2:0]  ret_valid;
  logic [11:0] ret_idx;
  logic        flush_valid;
  logic [3:0]  flush_idx;
  logic        flush_taken;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int exp_q[$];
  int mon_e;

  always #4 clk = ~clk;

  rob_retire_unit dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_nuops(alloc_nuops), .alloc_branch(alloc_branch),
    .alloc_pred_taken(alloc_pred_taken), .alloc_idx(alloc_idx),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_taken(cpl_taken),
    .ret_valid(ret_valid), .ret_idx(ret_idx),
    .flush_valid(flush_valid), .flush_idx(flush_idx), .flush_taken(flush_taken)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic do_alloc(input int n, input bit br, input bit pr, output int idx);
    alloc_valid = 1'b1;
    alloc_nuops = 3'(n);
    alloc_branch = br;
    alloc_pred_taken = pr;
    while (!alloc_ready) @(negedge clk);
    idx = int'(alloc_idx);
    exp_q.push_back(idx);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic complete(input bit v0, input int i0, input bit v1, input int i1,
                          input bit tk);
    cpl_valid = {v1, v0};
    cpl_idx   = {4'(i1), 4'(i0)};
    cpl_taken = {tk, tk};
    @(negedge clk);
    cpl_valid = '0;
  endtask

  // Monitor: pops the expected order as lanes retire (R4, R5).
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int k = 0; k < 3; k++) begin
        if (ret_valid[k]) begin
          if (k > 0 && !ret_valid[k-1])
            chk(1'b0, "R5", "lane gap", k, k - 1);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected retire idx", int'(ret_idx[k*IDXW +: IDXW]), -1);
          end else begin
            mon_e = exp_q.pop_front();
            chk(int'(ret_idx[k*IDXW +: IDXW]) == mon_e, "R4", "retire order",
                int'(ret_idx[k*IDXW +: IDXW]), mon_e);
          end
        end
      end
      if (flush_valid) exp_q.delete();
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run still busy, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b, c, d, e, f, g, h, i, j, k, l, m, n, p, q, s;
    int ids[16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R1 first index
    chk(alloc_ready == 1'b1, "R10", "ready after reset", alloc_ready, 1);
    chk(ret_valid == 3'b000, "R10", "no retire after reset", ret_valid, 0);
    chk(flush_valid == 1'b0, "R10", "no flush after reset", flush_valid, 0);
    chk(alloc_idx == 4'd0, "R1", "first index", alloc_idx, 0);

    // In-order with youngest completing first
    do_alloc(2, 0, 0, a);
    do_alloc(1, 0, 0, b);
    do_alloc(1, 0, 0, c);
    chk(a == 0 && b == 1 && c == 2, "R1", "sequential indices", c, 2);
    complete(1, b, 1, c, 0);
    chk(ret_valid == 3'b000, "R4", "younger done waits", ret_valid, 0);
    complete(1, a, 0, 0, 0);
    chk(ret_valid == 3'b000, "R3", "half-done slot waits", ret_valid, 0);
    complete(1, a, 0, 0, 0);
    chk(ret_valid == 3'b111, "R6", "retire next cycle", ret_valid, 7);
    chk(ret_idx[11:8] == 4'(c), "R5", "lane 2 index", ret_idx[11:8], c);
    @(negedge clk);
    chk(ret_valid == 3'b000, "R5", "drained", ret_valid, 0);

    // Two reports on one slot in one cycle
    do_alloc(2, 0, 0, d);
    complete(1, d, 1, d, 0);
    chk(ret_valid == 3'b001, "R7", "dual-port same slot", ret_valid, 1);
    @(negedge clk);

    // Four done at once: three retire, then one
    do_alloc(1, 0, 0, e);
    do_alloc(1, 0, 0, f);
    do_alloc(1, 0, 0, g);
    do_alloc(1, 0, 0, h);
    complete(1, g, 1, h, 0);
    chk(ret_valid == 3'b000, "R4", "older pending", ret_valid, 0);
    complete(1, e, 1, f, 0);
    chk(ret_valid == 3'b111, "R5", "three-lane cap", ret_valid, 7);
    @(negedge clk);
    chk(ret_valid == 3'b001, "R5", "remainder next cycle", ret_valid, 1);
    chk(ret_idx[3:0] == 4'(h), "R5", "remainder on lane 0", ret_idx[3:0], h);
    @(negedge clk);

    // Four micro-ops
    do_alloc(4, 0, 0, i);
    complete(1, i, 1, i, 0);
    chk(ret_valid == 3'b000, "R3", "2 of 4", ret_valid, 0);
    complete(1, i, 0, 0, 0);
    chk(ret_valid == 3'b000, "R3", "3 of 4", ret_valid, 0);
    complete(1, i, 0, 0, 0);
    chk(ret_valid == 3'b001, "R3", "4 of 4", ret_valid, 1);
    @(negedge clk);

    // Correctly predicted branch
    do_alloc(1, 1, 1, j);
    complete(1, j, 0, 0, 1);
    chk(ret_valid == 3'b001, "R8", "good branch retires", ret_valid, 1);
    chk(flush_valid == 1'b0, "R8", "good branch no flush", flush_valid, 0);
    @(negedge clk);

    // Mispredict on lane 0 with done younger slots
    do_alloc(1, 1, 0, k);
    do_alloc(1, 0, 0, l);
    do_alloc(1, 0, 0, m);
    complete(1, l, 1, m, 0);
    chk(ret_valid == 3'b000, "R4", "branch pending", ret_valid, 0);
    complete(1, k, 0, 0, 1);
    chk(ret_valid == 3'b001, "R8", "branch alone retires", ret_valid, 1);
    chk(flush_valid == 1'b1, "R8", "flush raised", flush_valid, 1);
    chk(flush_idx == 4'(k), "R8", "flush index", flush_idx, k);
    chk(flush_taken == 1'b1, "R8", "flush direction", flush_taken, 1);
    chk(alloc_ready == 1'b0, "R9", "ready low in flush cycle", alloc_ready, 0);
    for (int r = 1; r <= 10; r++) begin
      @(negedge clk);
      chk(alloc_ready == 1'b0, "R9", "recovery blocks", r, 0);
      chk(ret_valid == 3'b000, "R8", "younger discarded", ret_valid, 0);
    end
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R9", "ready after recovery", alloc_ready, 1);
    chk(alloc_idx == 4'(k + 1), "R9", "resume index", alloc_idx, k + 1);

    // Stale reports to an empty slot are ignored
    complete(1, k + 1, 1, k + 1, 0);
    do_alloc(1, 0, 0, n);
    chk(n == k + 1, "R9", "index after flush", n, k + 1);
    repeat (2) @(negedge clk);
    chk(ret_valid == 3'b000, "R3", "stale report ignored", ret_valid, 0);
    complete(1, n, 0, 0, 0);
    chk(ret_valid == 3'b001, "R3", "own report retires", ret_valid, 1);
    @(negedge clk);

    // Fill to 16
    for (int x = 0; x < 16; x++) do_alloc(1, 0, 0, ids[x]);
    chk(alloc_ready == 1'b0, "R2", "full refuses", alloc_ready, 0);
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    chk(alloc_ready == 1'b0, "R2", "still full", alloc_ready, 0);
    for (int x = 0; x < 16; x += 2) complete(1, ids[x], 1, ids[x+1], 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all retired in order", exp_q.size(), 0);
    chk(alloc_ready == 1'b1, "R2", "ready after drain", alloc_ready, 1);

    // Mispredict on lane 1 behind an older slot, younger done slot cut
    do_alloc(1, 0, 0, p);
    do_alloc(1, 1, 1, q);
    do_alloc(1, 0, 0, s);
    complete(1, s, 0, 0, 0);
    complete(1, p, 1, q, 0);
    chk(ret_valid == 3'b011, "R8", "cut after branch lane", ret_valid, 3);
    chk(flush_valid == 1'b1, "R8", "flush lane 1", flush_valid, 1);
    chk(flush_idx == 4'(q), "R8", "flush index lane 1", flush_idx, q);
    chk(flush_taken == 1'b0, "R8", "flush not-taken", flush_taken, 0);
    @(negedge clk);
    chk(ret_valid == 3'b000, "R8", "younger slot gone", ret_valid, 0);
    repeat (11) @(negedge clk);
    chk(alloc_idx == 4'(q + 1), "R9", "resume after lane-1 flush", alloc_idx, q + 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule